// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a timer that software drives through a small word-wide register interface. Software loads a prescale value and a period value, then writes a start pulse. The prescaler divides the clock: it counts down from its loaded value and gives one tick each time it reaches one. The period counter steps down by one on each tick. When the period counter is at one and a tick arrives, the interval is over and the running flag drops on that same edge, with no extra cycle.

The interval lasts exactly prescale × period clock cycles. A prescale of zero bypasses division, so the period counter steps on every clock. Separate stop and start pulses let software halt a count or restart it. The current period count can be read back. The prescaler's internal count cannot be read. Reads are combinational. A write takes effect on the next clock edge.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, the prescale and period registers both read 1, the current count reads 0, the status reads 0 and `running` is low.
- R2: Register map by word address: 0 is control (write bit 0 = start pulse, bit 1 = stop pulse; reads 0); 1 is status (bit 0 = running); 2 is prescale; 3 is period; 4 is the current count (read only). Any other address reads 0. Reads need `cs` high; otherwise `rdata` is 0.
- R3: With prescale P ≥ 1 and period T ≥ 1, `running` stays high for exactly P×T cycles after the start edge. No cycle is lost when the prescaler reloads.
- R4: With prescale 0, the period counter steps on every clock, so the interval lasts T cycles.
- R5: The current count steps down by one every P cycles. It stops at 1 when the interval ends and holds there.
- R6: A stop pulse clears `running` on the next edge and freezes the current count.
- R7: A control write with both start and stop set acts as a stop. It never sets `running`.
- R8: Writes to the prescale and period registers are ignored while `running` is high.
- R9: A start pulse while running reloads both counters and begins a full new interval.
- R10: A period of 0 acts like a period of 1. The interval lasts max(P,1) cycles and the count stays 0.
- R11: A start pulse sets `running` and loads the period value into the current count, both visible after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for a register access |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | 3 | Word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data (combinational) |
| running | output | 1 | High while an interval is counting |

## Verification
Pairs of prescale and period are run through a table. The pairs are chosen so that each case is distinguishable from the others:
- unit prescale against larger prescales, which separates a correct product from one that drops a cycle at each prescaler reload;
- a zero prescale, which shows the bypass;
- a zero period, which shows its treatment as one.

Directed sequences sample the current count partway through an interval. They then stop it, restart it, and combine the start and stop bits, to show the count stepping, freezing and reloading. Writes to the value registers during a count show whether they are ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_PRE  = 3'd2,
    A_PER  = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;

  // terminal test shared by both counters: zero or one ends a cycle
  function automatic logic at_last(input logic [63:0] v);
    return v <= 64'd1;
  endfunction

  function automatic logic [63:0] step_down(input logic [63:0] v);
    return v - 64'd1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    wdata,
  input  logic                running,
  input  logic [CNT_W-1:0]    cur_cnt,
  output logic [CNT_W-1:0]    rdata,
  output logic                start_p,
  output logic                stop_p,
  output logic [CNT_W-1:0]    pre_init,
  output logic [CNT_W-1:0]    per_init
);
  logic wr;
  logic wr_ctrl;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] per_q;

  assign wr      = cs && we;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign start_p = wr_ctrl && wdata[CTRL_START_BIT];
  assign stop_p  = wr_ctrl && wdata[CTRL_STOP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= CNT_W'(1);
      per_q <= CNT_W'(1);
    end else if (wr && !running) begin
      if (addr == A_PRE) pre_q <= wdata;
      if (addr == A_PER) per_q <= wdata;
    end
  end

  assign pre_init = pre_q;
  assign per_init = per_q;

  always_comb begin
    rdata = '0;
    if (cs) begin
      case (addr)
        A_STAT:  rdata = CNT_W'(running);
        A_PRE:   rdata = pre_q;
        A_PER:   rdata = per_q;
        A_CNT:   rdata = cur_cnt;
        default: rdata = '0;
      endcase
    end
  end

  // R8: value registers hold while a count is active
  p_init_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(pre_q) && $stable(per_q)));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [CNT_W-1:0] init,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = en && at_last(64'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= CNT_W'(1);
    else if (load)   cnt <= init;
    else if (tick)   cnt <= init;
    else if (en)     cnt <= CNT_W'(step_down(64'(cnt)));
  end

  // checker: cycles elapsed since the last tick or load
  logic [CNT_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= CNT_W'(1);
    else if (load || !en || tick) gap <= CNT_W'(1);
    else                       gap <= gap + CNT_W'(1);
  end

  // R3: ticks are spaced exactly by the prescale value, none lost on reload
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && init != '0) |-> (gap == init));
  // R4: zero prescale ticks every active cycle
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && init == '0 && $past(init) == '0) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic [CNT_W-1:0] init,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  assign expire = tick && at_last(64'(cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= init;
    end else if (expire) begin
      running <= 1'b0;
    end else if (tick) begin
      cnt <= CNT_W'(step_down(64'(cnt)));
    end
  end

  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && $stable(cnt)));
  p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stop) |=> !running);
  p_start_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (running && cnt == $past(init)));
  p_expire_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start && !stop) |=> (!running && cnt == $past(cnt)));
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> (cnt <= $past(cnt)));
  p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> (!running && $stable(cnt)));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    rdata,
  output logic                running
);
  logic             start_p;
  logic             stop_p;
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] pre_init;
  logic [CNT_W-1:0] per_init;
  logic [CNT_W-1:0] cur_cnt;
  logic             run_q;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .running(run_q), .cur_cnt(cur_cnt), .rdata(rdata),
    .start_p(start_p), .stop_p(stop_p),
    .pre_init(pre_init), .per_init(per_init)
  );

  tmr_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(start_p), .en(run_q),
    .init(pre_init), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start_p), .stop(stop_p), .tick(tick),
    .init(per_init), .cnt(cur_cnt), .running(run_q), .expire(expire)
  );

  assign running = run_q;

  // R3: an expiry can only come from a prescaler tick while active
  p_expire_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (tick && run_q));
endmodule

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        running;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  localparam logic [31:0] VEC_P [8] = '{32'd1, 32'd0, 32'd2, 32'd5, 32'd4, 32'd3, 32'd1, 32'd0};
  localparam logic [31:0] VEC_T [8] = '{32'd1, 32'd5, 32'd3, 32'd1, 32'd0, 32'd7, 32'd9, 32'd0};

  prescaled_timer #(.CNT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .running(running)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic int exp_len(input int p, input int t);
    int pe, te;
    pe = (p == 0) ? 1 : p;
    te = (t == 0) ? 1 : t;
    return pe * te;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    v = rdata;
    cs = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (running === 1'b1 && n < 50000) begin
      n = n + 1;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); check("R1 prescale reset", v, 1);
    rd(3'd3, v); check("R1 period reset", v, 1);
    rd(3'd4, v); check("R1 count reset", v, 0);
    rd(3'd1, v); check("R1 status reset", v, 0);
    check("R1 running reset", running, 0);
    // R2 map: unused address and control read back zero
    rd(3'd7, v); check("R2 unused addr", v, 0);
    rd(3'd0, v); check("R2 ctrl reads zero", v, 0);

    // R3 R4 R10 vector table walk
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, VEC_P[i]);
      wr(3'd3, VEC_T[i]);
      wr(3'd0, 32'd1);
      measure(n);
      check($sformatf("R3/R4/R10 length p=%0d t=%0d", VEC_P[i], VEC_T[i]),
            n, exp_len(int'(VEC_P[i]), int'(VEC_T[i])));
      rd(3'd4, v);
      check("R5 final count", v, (VEC_T[i] == 0) ? 0 : 1);
    end

    // R11 start loads, R5 stepping, R6 stop freezes
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd4);
    wr(3'd0, 32'd1);
    check("R11 running after start", running, 1);
    rd(3'd1, v); check("R2 status running", v, 1);
    rd(3'd4, v); check("R11 count loaded", v, 4);
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R5 count after one prescale", v, 3);
    wr(3'd0, 32'd2);
    check("R6 stopped", running, 0);
    rd(3'd4, v); check("R6 count at stop", v, 3);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R6 count frozen", v, 3);

    // R8 writes ignored while running
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd10);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'd7);
    rd(3'd2, v); check("R8 prescale kept", v, 2);
    wr(3'd3, 32'd9);
    rd(3'd3, v); check("R8 period kept", v, 10);
    measure(n);
    wr(3'd2, 32'd7);
    rd(3'd2, v); check("R8 prescale write when idle", v, 7);

    // R9 restart while running
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'd1);
    repeat (3) @(negedge clk);
    wr(3'd0, 32'd1);
    measure(n);
    check("R9 restart length", n, 5);

    // R7 both bits: acts as stop
    wr(3'd0, 32'd3);
    check("R7 idle both bits", running, 0);
    rd(3'd4, v); check("R7 count untouched", v, 1);
    wr(3'd0, 32'd1);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'd3);
    check("R7 running both bits", running, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule